// File: doc/BRIEF.md
# Multithreaded Instruction Buffer with Replay

This block holds fetched instructions for several hardware threads, one ring buffer per thread, between a shared fetch unit and the stage that picks a thread to dispatch. Fetch writes one instruction per cycle, tagged with a thread number. Each thread reports whether it has something ready to dispatch and whether its ring is full, so fetch can run ahead and keep every ring topped up. Each cycle a selector outside the block names one thread, and the block issues that thread's next instruction one cycle later.

An issued instruction stays in its ring until the pipeline retires it. The ring therefore also serves as a skid buffer. When an issued instruction stalls or is killed, the pipeline sends a rewind that moves the thread's issue pointer back to the affected instruction. The same instruction and all younger ones are then issued again from the ring, and nothing is fetched a second time. A per-thread flush, such as on a branch redirect, empties one thread's ring. Each ring keeps three pointers: write, issue and retire. Pointers are one bit wider than the slot index, and the top bit marks the wrap.

Top module: `mt_ibuf`

## Requirements
- R1: A fetch write (`fe_valid`) that is not dropped goes into the ring of thread `fe_tid`. Instructions of one thread are issued in the order they were written.
- R2: `fe_full[t]` is high exactly when thread t holds DEPTH (default 8) entries counted from its retire pointer. A write to a full thread is dropped and does not overwrite an entry that has not retired.
- R3: `rdy[t]` is high exactly when thread t's issue pointer differs from its write pointer.
- R4: A cycle with `sel_valid` high and `rdy[sel_tid]` high gives, on the next cycle, `disp_valid`=1, `disp_tid`=`sel_tid`, `disp_instr` equal to the entry at the issue pointer, and `disp_pos` equal to that pointer (slot index in the low bits, wrap bit on top). The pointer then advances by one. When the named thread is not ready, `disp_valid` is 0 on the next cycle.
- R5: Issued entries stay in the ring until they retire. `cmt_valid` retires the oldest entry of `cmt_tid` only when that entry has been issued; otherwise the request is ignored.
- R6: A rewind (`rw_valid`, `rw_tid`, `rw_pos`) with `rw_pos` between the retire pointer (taken after any retire in the same cycle) and the issue pointer, counted modulo 2*DEPTH, sets the issue pointer to `rw_pos` in that cycle. Later issues replay the same instructions. A rewind outside that window is ignored.
- R7: An accepted rewind for the thread named by `sel_tid` in the same cycle cancels that issue, so `disp_valid` is 0 on the next cycle.
- R8: A flush (`fl_valid`, `fl_tid`) sets all three pointers of that thread to empty. It takes priority over a write, issue, retire or rewind for that thread in the same cycle.
- R9: After reset every ring is empty: `rdy`=0, `fe_full`=0, `disp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_valid | input | 1 | Fetch write request |
| fe_tid | input | TID_W | Thread of fetched instruction |
| fe_instr | input | INSTR_W | Fetched instruction |
| fe_full | output | THREADS | Per-thread back-pressure |
| rdy | output | THREADS | Per-thread has instruction to issue |
| sel_valid | input | 1 | Selector requests an issue |
| sel_tid | input | TID_W | Thread chosen to issue |
| disp_valid | output | 1 | Issued instruction valid |
| disp_tid | output | TID_W | Thread of issued instruction |
| disp_instr | output | INSTR_W | Issued instruction |
| disp_pos | output | PTR_W | Ring position of issued instruction |
| cmt_valid | input | 1 | Retire oldest issued entry |
| cmt_tid | input | TID_W | Thread to retire from |
| rw_valid | input | 1 | Rewind request |
| rw_tid | input | TID_W | Thread to rewind |
| rw_pos | input | PTR_W | Position to restore the issue pointer to |
| fl_valid | input | 1 | Flush request |
| fl_tid | input | TID_W | Thread to flush |

## Verification
The random part interleaves fetch, select, retire, rewind and rare flush across all threads at once. A bench reference model tracks every instruction, so a wrong slot, a lost retire or a misplaced rewind shows up as a wrong `disp_instr` or `disp_pos`. Rewind targets are drawn inside the window and also one position past the issue pointer. This separates the accept path from the reject path. Directed cases fill a thread to the limit and then push once more, retire an entry that was never issued, and rewind to the oldest entry to force a full replay. They also put a rewind and a flush in the same cycle as a selection of the same thread, to check the priority order.

// File: rtl/mt_ibuf_pkg.sv
package mt_ibuf_pkg;
  localparam int DEF_THREADS = 4;
  localparam int DEF_DEPTH   = 8;
  localparam int DEF_INSTR_W = 32;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mt_ibuf_lane.sv
module mt_ibuf_lane #(
  parameter int DEPTH   = 8,
  parameter int INSTR_W = 32,
  parameter int PTR_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [INSTR_W-1:0] wr_data,
  input  logic               disp_en,
  input  logic               cmt_en,
  input  logic               rw_en,
  input  logic [PTR_W-1:0]   rw_pos,
  input  logic               fl_en,
  output logic               rdy,
  output logic               full,
  output logic               fire,
  output logic [PTR_W-1:0]   dp_out,
  output logic [INSTR_W-1:0] rd_data
);
  localparam int AW = PTR_W - 1;
  localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);

  logic [INSTR_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wr_q, dp_q, cm_q, cm_n;
  logic               do_wr, do_cm, rw_ok;

  assign full   = (wr_q - cm_q) == FULL_CNT;
  assign rdy    = dp_q != wr_q;
  assign dp_out = dp_q;

  always_comb begin
    do_wr = wr_en && !full && !fl_en;
    do_cm = cmt_en && (cm_q != dp_q) && !fl_en;
    cm_n  = do_cm ? cm_q + 1'b1 : cm_q;
    rw_ok = rw_en && !fl_en && ((rw_pos - cm_n) <= (dp_q - cm_n));
    fire  = disp_en && rdy && !fl_en && !rw_ok;
  end

  always_ff @(posedge clk) begin
    if (rst || fl_en) begin
      wr_q <= '0;
      dp_q <= '0;
      cm_q <= '0;
    end else begin
      if (do_wr) wr_q <= wr_q + 1'b1;
      cm_q <= cm_n;
      if (rw_ok)     dp_q <= rw_pos;
      else if (fire) dp_q <= dp_q + 1'b1;
    end
  end

  // storage: one write port, one synchronous read port
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_q[AW-1:0]] <= wr_data;
    rd_data <= mem[dp_q[AW-1:0]];
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (wr_q - cm_q) <= FULL_CNT);
  a_r5_order: assert property (@(posedge clk) disable iff (rst)
    (dp_q - cm_q) <= (wr_q - cm_q));
  a_r2_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !fl_en) |=> $stable(wr_q));
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (rst)
    fl_en |=> (wr_q == cm_q && dp_q == cm_q && !rdy));
endmodule

// File: rtl/mt_ibuf_pick.sv
module mt_ibuf_pick #(
  parameter int N  = 4,
  parameter int W  = 32,
  parameter int TW = 2
) (
  input  logic [N-1:0][W-1:0] in_data,
  input  logic [TW-1:0]       sel,
  output logic [W-1:0]        out_data
);
  always_comb begin
    out_data = '0;
    for (int i = 0; i < N; i++)
      if (sel == TW'(i)) out_data = in_data[i];
  end
endmodule

// File: rtl/mt_ibuf.sv
module mt_ibuf
  import mt_ibuf_pkg::*;
#(
  parameter int THREADS = DEF_THREADS,
  parameter int DEPTH   = DEF_DEPTH,
  parameter int INSTR_W = DEF_INSTR_W,
  localparam int TID_W  = idx_w(THREADS),
  localparam int PTR_W  = idx_w(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fe_valid,
  input  logic [TID_W-1:0]   fe_tid,
  input  logic [INSTR_W-1:0] fe_instr,
  output logic [THREADS-1:0] fe_full,
  output logic [THREADS-1:0] rdy,
  input  logic               sel_valid,
  input  logic [TID_W-1:0]   sel_tid,
  output logic               disp_valid,
  output logic [TID_W-1:0]   disp_tid,
  output logic [INSTR_W-1:0] disp_instr,
  output logic [PTR_W-1:0]   disp_pos,
  input  logic               cmt_valid,
  input  logic [TID_W-1:0]   cmt_tid,
  input  logic               rw_valid,
  input  logic [TID_W-1:0]   rw_tid,
  input  logic [PTR_W-1:0]   rw_pos,
  input  logic               fl_valid,
  input  logic [TID_W-1:0]   fl_tid
);
  logic [THREADS-1:0]              lane_fire;
  logic [THREADS-1:0][PTR_W-1:0]   lane_dp;
  logic [THREADS-1:0][INSTR_W-1:0] lane_rd;
  logic [PTR_W-1:0]                sel_dp;

  for (genvar t = 0; t < THREADS; t++) begin : g_lane
    mt_ibuf_lane #(.DEPTH(DEPTH), .INSTR_W(INSTR_W), .PTR_W(PTR_W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (fe_valid  && fe_tid  == TID_W'(t)),
      .wr_data (fe_instr),
      .disp_en (sel_valid && sel_tid == TID_W'(t)),
      .cmt_en  (cmt_valid && cmt_tid == TID_W'(t)),
      .rw_en   (rw_valid  && rw_tid  == TID_W'(t)),
      .rw_pos  (rw_pos),
      .fl_en   (fl_valid  && fl_tid  == TID_W'(t)),
      .rdy     (rdy[t]),
      .full    (fe_full[t]),
      .fire    (lane_fire[t]),
      .dp_out  (lane_dp[t]),
      .rd_data (lane_rd[t])
    );
  end

  mt_ibuf_pick #(.N(THREADS), .W(PTR_W), .TW(TID_W)) u_pos_pick (
    .in_data (lane_dp), .sel (sel_tid), .out_data (sel_dp));

  mt_ibuf_pick #(.N(THREADS), .W(INSTR_W), .TW(TID_W)) u_data_pick (
    .in_data (lane_rd), .sel (disp_tid), .out_data (disp_instr));

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= 1'b0;
      disp_tid   <= '0;
      disp_pos   <= '0;
    end else begin
      disp_valid <= |lane_fire;
      disp_tid   <= sel_tid;
      disp_pos   <= sel_dp;
    end
  end

  a_r4_disp_from_sel: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> $past(sel_valid));
  a_r8_flush_cancels: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && fl_valid && fl_tid == sel_tid) |=> !disp_valid);
endmodule

// File: tb/tb_mt_ibuf.sv
`timescale 1ns/1ps
module tb_mt_ibuf;
  localparam int NT = 4;
  localparam int D  = 8;
  localparam int TW = 2;
  localparam int PW = 4;

  logic clk = 0, rst = 1;
  logic fe_valid = 0; logic [TW-1:0] fe_tid = 0; logic [31:0] fe_instr = 0;
  logic [NT-1:0] fe_full, rdy;
  logic sel_valid = 0; logic [TW-1:0] sel_tid = 0;
  logic disp_valid; logic [TW-1:0] disp_tid; logic [31:0] disp_instr; logic [PW-1:0] disp_pos;
  logic cmt_valid = 0; logic [TW-1:0] cmt_tid = 0;
  logic rw_valid = 0; logic [TW-1:0] rw_tid = 0; logic [PW-1:0] rw_pos = 0;
  logic fl_valid = 0; logic [TW-1:0] fl_tid = 0;

  mt_ibuf dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, seq = 0;
  int m_wr[NT], m_dp[NT], m_cm[NT];
  logic [31:0] m_mem[NT][D];
  logic e_v; int e_tid; logic [31:0] e_instr; int e_pos;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_instr(input int t);
    seq++;
    return {8'(t), 24'(seq)};
  endfunction

  function automatic logic m_full(input int t);
    return (m_wr[t] - m_cm[t]) == D;
  endfunction

  // one cycle: drive, update model, wait, compare
  task automatic step(input logic fv, input int ft, input logic sv, input int st,
                      input logic cv, input int ct, input logic rv, input int rt,
                      input int rk, input logic flv, input int flt);
    logic [31:0] ins;
    ins = next_instr(ft);
    fe_valid = fv; fe_tid = TW'(ft); fe_instr = ins;
    sel_valid = sv; sel_tid = TW'(st);
    cmt_valid = cv; cmt_tid = TW'(ct);
    rw_valid = rv; rw_tid = TW'(rt); rw_pos = PW'(rk);
    fl_valid = flv; fl_tid = TW'(flt);
    e_v = 0;
    for (int t = 0; t < NT; t++) begin
      if (flv && flt == t) begin
        m_wr[t] = 0; m_dp[t] = 0; m_cm[t] = 0;
      end else begin
        logic dw, dc, rok, dd; int cmn;
        dw  = fv && ft == t && !m_full(t);
        dc  = cv && ct == t && m_cm[t] != m_dp[t];
        cmn = m_cm[t] + (dc ? 1 : 0);
        rok = rv && rt == t && ((rk - cmn) & 15) <= (m_dp[t] - cmn);
        dd  = sv && st == t && m_dp[t] != m_wr[t] && !rok;
        if (dd) begin
          e_v = 1; e_tid = t; e_instr = m_mem[t][m_dp[t] % D]; e_pos = m_dp[t] & 15;
        end
        if (dw) begin m_mem[t][m_wr[t] % D] = ins; m_wr[t]++; end
        m_cm[t] = cmn;
        if (rok) m_dp[t] = m_cm[t] + (((rk - cmn) & 15));
        else if (dd) m_dp[t]++;
      end
    end
    @(negedge clk);
    chk("R4 disp_valid", disp_valid, e_v);
    if (e_v) begin
      chk("R4 disp_tid", disp_tid, e_tid);
      chk("R1 disp_instr", disp_instr, e_instr);
      chk("R4 disp_pos", disp_pos, e_pos);
    end
    for (int t = 0; t < NT; t++) begin
      chk("R3 rdy", rdy[t], m_dp[t] != m_wr[t]);
      chk("R2 fe_full", fe_full[t], m_full(t));
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    for (int t = 0; t < NT; t++) begin m_wr[t] = 0; m_dp[t] = 0; m_cm[t] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R9 rdy after reset", rdy, 0);
    chk("R9 full after reset", fe_full, 0);
    chk("R9 disp_valid after reset", disp_valid, 0);

    // R2: fill thread 0, push once more
    for (int i = 0; i < D + 1; i++) step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 full at depth", fe_full[0], 1);
    // R5: retire with nothing issued is ignored; issue all, still full
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R5 retire of unissued ignored", fe_full[0], 1);
    for (int i = 0; i < D; i++) step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 issued entries retained", fe_full[0], 1);
    // R6: rewind to oldest, replay first entry
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R6 rewind makes ready", rdy[0], 1);
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 replay position", disp_pos, 0);
    // R6: out-of-window rewind (past issue pointer) ignored
    step(0, 0, 0, 0, 0, 0, 1, 0, m_dp[0] + 1, 0, 0);
    // R7: rewind with same-thread selection cancels issue
    step(0, 0, 1, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R7 issue cancelled", disp_valid, 0);
    // R8: flush with selection and write same cycle
    step(1, 0, 1, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R8 flush empties", {fe_full[0], rdy[0]}, 0);
    chk("R8 flush cancels issue", disp_valid, 0);

    // random mix
    for (int c = 0; c < 4000; c++) begin
      int ft, st, ct, rt, rk;
      logic rv;
      ft = $urandom_range(0, NT-1); st = $urandom_range(0, NT-1);
      ct = $urandom_range(0, NT-1); rt = $urandom_range(0, NT-1);
      rv = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 7) == 0) rk = m_dp[rt] + 1;
      else rk = m_cm[rt] + $urandom_range(0, m_dp[rt] - m_cm[rt]);
      step($urandom_range(0, 3) != 0, ft, $urandom_range(0, 3) != 0, st,
           $urandom_range(0, 2) == 0, ct, rv, rt, rk,
           $urandom_range(0, 63) == 0, $urandom_range(0, NT-1));
    end
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule